// File: doc/BRIEF.md
# Parallel Display Controller Slave Port

This block is the controller side of a 16-bit parallel display bus with separate strobes. The host drives an active-low select, separate active-low write and read strobes, and a register/data select line. An access with the select line low loads a register index. An access with the select line high moves data to or from whatever that index names. The index can name a small set of configuration registers, a fixed device identifier, two position registers, or a pixel memory. Pixel writes land at a position held in the position registers, and that position advances after every pixel.

All bus inputs are asynchronous to the core clock. The write strobe and the bus bundle go through a two-stage synchronizer. A write takes effect on the rising edge of the synchronized write strobe. Read data is driven combinationally from core state for as long as select and read are both low. Typical use is to set X and Y, write index 0x22, and then stream pixels. To read a register, write its index and then pulse the read strobe.

Top module: `lcdp_slave`

## Requirements
- R1: While `bus_rst_n` is low, and after it returns high, the index is 0x00 and the mode register, display register, X position and Y position are all zero.
- R2: `bus_db_oe` is high only while `bus_cs_n` and `bus_rd_n` are both low. While `bus_db_oe` is low, `bus_db_out` is zero.
- R3: A write strobe seen while `bus_cs_n` is high changes no state.
- R4: A write with `bus_rs`=0 loads `bus_db_in[7:0]` as the index. A write with `bus_rs`=1 stores the word in the indexed register: mode at 0x03, display at 0x07.
- R5: A read returns the value of the indexed register. Index 0x00 returns the device ID 0x5A17.
- R6: Data writes to index 0x00 are ignored.
- R7: Data writes to any index other than 0x03, 0x07, 0x20, 0x21 and 0x22 are ignored, and reads of those indices return zero.
- R8: A data write to index 0x22 stores the pixel at address Y*16+X. A read of index 0x22 returns the pixel at the current position and does not move it.
- R9: After each pixel write X increments. When X passes 15 it returns to 0 and Y increments. When Y passes 7 it returns to 0.
- R10: Index 0x20 holds X and takes the low 4 bits of the written word. Index 0x21 holds Y and takes the low 3 bits. Both read back zero-extended.
- R11: A write takes effect at the third core clock edge after `bus_wr_n` rises. A write whose strobe rises while `bus_rd_n` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| bus_rst_n | input | 1 | Active-low reset from the bus |
| bus_cs_n | input | 1 | Active-low select |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_rs | input | 1 | 0 = index access, 1 = data access |
| bus_db_in | input | 16 | Data bus from the host |
| bus_db_out | output | 16 | Data bus toward the host |
| bus_db_oe | output | 1 | Drive enable for the data bus |

## Verification
Every write must finish its three-edge trip through the synchronizer and edge detector before its effect can be seen. The bench therefore holds each strobe bundle for four core edges before anything reads state back. Read results are combinational and are sampled at the falling clock edge that follows the drop of the read strobe. One directed sequence lowers the read strobe after exactly two edges and expects the old value, then samples again after the third edge and expects the new one. This pins the write latency to the cycle.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_MODE = 8'h03;
    localparam logic [7:0] IDX_DISP = 8'h07;
    localparam logic [7:0] IDX_COLX = 8'h20;
    localparam logic [7:0] IDX_ROWY = 8'h21;
    localparam logic [7:0] IDX_PIX  = 8'h22;
endpackage

// File: rtl/lcdp_sync.sv
module lcdp_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= d_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= RST_VAL;
            else        stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lcdp_pixram.sv
module lcdp_pixram #(
    parameter int DW    = 16,
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[addr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[addr_i];

    // R8
    pix_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/lcdp_ctrl.sv
module lcdp_ctrl
    import lcdp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int COLS = 16,
    parameter int ROWS = 8,
    parameter int XW   = $clog2(COLS),
    parameter int YW   = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   s_db_i,
    input  logic            s_rs_i,
    input  logic            s_cs_n_i,
    input  logic            s_rd_n_i,
    input  logic            s_wr_n_i,
    output logic [7:0]      index_o,
    output logic [DW-1:0]   mode_o,
    output logic [DW-1:0]   disp_o,
    output logic [XW-1:0]   x_o,
    output logic [YW-1:0]   y_o,
    output logic            pix_we_o,
    output logic [XW+YW-1:0] pix_addr_o
);
    localparam logic [XW-1:0] XMAX = XW'(COLS - 1);
    localparam logic [YW-1:0] YMAX = YW'(ROWS - 1);

    typedef struct packed {
        logic [7:0]    idx;
        logic [DW-1:0] mode;
        logic [DW-1:0] disp;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic          wr_prev;
    } st_t;

    st_t  st_d, st_q;
    logic fire, idx_fire, data_fire;

    assign fire      = s_wr_n_i && !st_q.wr_prev && !s_cs_n_i && s_rd_n_i;
    assign idx_fire  = fire && !s_rs_i;
    assign data_fire = fire && s_rs_i;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = s_wr_n_i;
        pix_we_o     = 1'b0;
        if (idx_fire) st_d.idx = s_db_i[7:0];
        if (data_fire) begin
            case (st_q.idx)
                IDX_MODE: st_d.mode = s_db_i;
                IDX_DISP: st_d.disp = s_db_i;
                IDX_COLX: st_d.x    = s_db_i[XW-1:0];
                IDX_ROWY: st_d.y    = s_db_i[YW-1:0];
                IDX_PIX: begin
                    pix_we_o = 1'b1;
                    if (st_q.x == XMAX) begin
                        st_d.x = '0;
                        st_d.y = (st_q.y == YMAX) ? '0 : st_q.y + 1'b1;
                    end else begin
                        st_d.x = st_q.x + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{idx: '0, mode: '0, disp: '0, x: '0, y: '0, wr_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign index_o    = st_q.idx;
    assign mode_o     = st_q.mode;
    assign disp_o     = st_q.disp;
    assign x_o        = st_q.x;
    assign y_o        = st_q.y;
    assign pix_addr_o = {st_q.y, st_q.x};

    // R4
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_fire |=> st_q.idx == $past(s_db_i[7:0]));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_fire |=> $stable(st_q.mode) && $stable(st_q.disp)
                       && $stable(st_q.x) && $stable(st_q.y));

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_fire && st_q.idx == IDX_PIX) |=>
            {st_q.y, st_q.x} == (XW+YW)'($past({st_q.y, st_q.x}) + 1'b1));

    // R11
    fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/lcdp_slave.sv
module lcdp_slave
    import lcdp_pkg::*;
#(
    parameter int          DW        = 16,
    parameter int          COLS      = 16,
    parameter int          ROWS      = 8,
    parameter logic [15:0] DEVICE_ID = 16'h5A17
) (
    input  logic          clk,
    input  logic          bus_rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_wr_n,
    input  logic          bus_rd_n,
    input  logic          bus_rs,
    input  logic [DW-1:0] bus_db_in,
    output logic [DW-1:0] bus_db_out,
    output logic          bus_db_oe
);
    localparam int XW    = $clog2(COLS);
    localparam int YW    = $clog2(ROWS);
    localparam int DEPTH = COLS * ROWS;
    localparam int BW    = DW + 4;
    localparam logic [BW-1:0] BUNDLE_RST = {1'b1, 1'b1, 1'b1, 1'b0, {DW{1'b0}}};

    logic [BW-1:0]      bundle_s;
    logic [DW-1:0]      s_db;
    logic               s_wr_n, s_rd_n, s_cs_n, s_rs;
    logic [7:0]         index;
    logic [DW-1:0]      mode, disp, pix_rdata, rd_mux;
    logic [XW-1:0]      x;
    logic [YW-1:0]      y;
    logic               pix_we;
    logic [XW+YW-1:0]   pix_addr;

    lcdp_sync #(.W(BW), .STAGES(2), .RST_VAL(BUNDLE_RST)) u_sync (
        .clk   (clk),
        .rst_n (bus_rst_n),
        .d_i   ({bus_wr_n, bus_rd_n, bus_cs_n, bus_rs, bus_db_in}),
        .q_o   (bundle_s)
    );

    assign {s_wr_n, s_rd_n, s_cs_n, s_rs, s_db} = bundle_s;

    lcdp_ctrl #(.DW(DW), .COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW)) u_ctrl (
        .clk        (clk),
        .rst_n      (bus_rst_n),
        .s_db_i     (s_db),
        .s_rs_i     (s_rs),
        .s_cs_n_i   (s_cs_n),
        .s_rd_n_i   (s_rd_n),
        .s_wr_n_i   (s_wr_n),
        .index_o    (index),
        .mode_o     (mode),
        .disp_o     (disp),
        .x_o        (x),
        .y_o        (y),
        .pix_we_o   (pix_we),
        .pix_addr_o (pix_addr)
    );

    lcdp_pixram #(.DW(DW), .DEPTH(DEPTH), .AW(XW+YW)) u_ram (
        .clk     (clk),
        .rst_n   (bus_rst_n),
        .we_i    (pix_we),
        .addr_i  (pix_addr),
        .wdata_i (s_db),
        .rdata_o (pix_rdata)
    );

    always_comb begin
        case (index)
            IDX_ID:   rd_mux = DW'(DEVICE_ID);
            IDX_MODE: rd_mux = mode;
            IDX_DISP: rd_mux = disp;
            IDX_COLX: rd_mux = DW'(x);
            IDX_ROWY: rd_mux = DW'(y);
            IDX_PIX:  rd_mux = pix_rdata;
            default:  rd_mux = '0;
        endcase
    end

    assign bus_db_oe  = !bus_cs_n && !bus_rd_n;
    assign bus_db_out = bus_db_oe ? rd_mux : '0;
endmodule

// File: tb/test_lcdp_slave.sv
`timescale 1ns/1ps
module test_lcdp_slave;
    logic        clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1, bus_rs = 1'b0;
    logic [15:0] bus_db_in = '0;
    logic [15:0] bus_db_out;
    logic        bus_db_oe;

    lcdp_slave i_lcdp_slave (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic [15:0] data;
        logic        oe;
        string       tag;
    } exp_t;

    exp_t  sb_q[$];
    bit    req = 1'b0;
    bit    done = 1'b0;
    int    vectors = 0;
    int    fails = 0;

    // monitor: pops one expected item per request at the falling edge
    always @(negedge clk) begin
        if (req) begin
            exp_t e;
            e = sb_q.pop_front();
            vectors++;
            if (bus_db_oe !== e.oe || bus_db_out !== e.data) begin
                fails++;
                $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
                         e.tag, bus_db_oe, bus_db_out, e.oe, e.data);
            end
            req = 1'b0;
        end
    end

    task automatic bus_wr(input logic rsel, input logic [15:0] w,
                          input logic sel_n, input logic rd_low);
        @(posedge clk); #2;
        bus_cs_n = sel_n; bus_rs = rsel; bus_db_in = w;
        bus_rd_n = !rd_low; bus_wr_n = 1'b0;
        repeat (2) @(posedge clk); #2;
        bus_wr_n = 1'b1;
        repeat (4) @(posedge clk); #2;
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    endtask

    task automatic push(input logic [15:0] d, input logic oe, input string tag);
        exp_t e;
        e.data = d; e.oe = oe; e.tag = tag;
        sb_q.push_back(e);
        req = 1'b1;
        wait (req == 1'b0);
    endtask

    task automatic expect_rd(input logic [15:0] d, input string tag);
        @(posedge clk); #2;
        bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        push(d, 1'b1, tag);
        #1; bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    endtask

    task automatic rd_reg(input logic [7:0] idx, input logic [15:0] d, input string tag);
        bus_wr(1'b0, {8'h00, idx}, 1'b0, 1'b0);
        expect_rd(d, tag);
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [15:0] d);
        bus_wr(1'b0, {8'h00, idx}, 1'b0, 1'b0);
        bus_wr(1'b1, d, 1'b0, 1'b0);
    endtask

    task automatic expect_idle(input logic sel_n, input logic rd_n, input string tag);
        @(posedge clk); #2;
        bus_cs_n = sel_n; bus_rd_n = rd_n;
        push(16'h0000, 1'b0, tag);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #2;
        bus_rst_n = 1'b1;
        // R1 reset state, index 0 gives the ID without an index write
        expect_rd(16'h5A17, "R1 reset index");
        rd_reg(8'h03, 16'h0000, "R1 mode reset");
        rd_reg(8'h07, 16'h0000, "R1 disp reset");
        rd_reg(8'h20, 16'h0000, "R1 X reset");
        rd_reg(8'h21, 16'h0000, "R1 Y reset");
        // R2 drive enable
        expect_idle(1'b1, 1'b1, "R2 idle");
        expect_idle(1'b1, 1'b0, "R2 cs high");
        expect_idle(1'b0, 1'b1, "R2 rd high");
        // R5, R6
        rd_reg(8'h00, 16'h5A17, "R5 ID");
        wr_reg(8'h00, 16'h1234);
        rd_reg(8'h00, 16'h5A17, "R6 ID read only");
        // R4
        wr_reg(8'h03, 16'hBEEF);
        wr_reg(8'h07, 16'h00FF);
        rd_reg(8'h03, 16'hBEEF, "R4 mode");
        rd_reg(8'h07, 16'h00FF, "R4 disp");
        // R7
        wr_reg(8'h55, 16'h7777);
        rd_reg(8'h55, 16'h0000, "R7 undefined read");
        rd_reg(8'h03, 16'hBEEF, "R7 mode untouched");
        // R3: index is 0x03 now; cs-high index and data writes are ignored
        bus_wr(1'b0, 16'h0007, 1'b1, 1'b0);
        bus_wr(1'b1, 16'h1111, 1'b1, 1'b0);
        expect_rd(16'hBEEF, "R3 cs high ignored");
        // R11 both strobes low is not a write
        bus_wr(1'b1, 16'h2222, 1'b0, 1'b1);
        expect_rd(16'hBEEF, "R11 rd low write ignored");
        // R11 latency: index is 0x03
        @(posedge clk); #2;
        bus_cs_n = 1'b0; bus_rs = 1'b1; bus_db_in = 16'h0F0F; bus_wr_n = 1'b0;
        repeat (2) @(posedge clk); #2;
        bus_wr_n = 1'b1;
        repeat (2) @(posedge clk); #2;
        bus_rd_n = 1'b0;
        push(16'hBEEF, 1'b1, "R11 before third edge");
        push(16'h0F0F, 1'b1, "R11 after third edge");
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
        // R8, R9 pixel stream across a row end
        wr_reg(8'h20, 16'd14);
        wr_reg(8'h21, 16'd2);
        bus_wr(1'b0, 16'h0022, 1'b0, 1'b0);
        bus_wr(1'b1, 16'hFFFF, 1'b0, 1'b0);
        bus_wr(1'b1, 16'h0001, 1'b0, 1'b0);
        bus_wr(1'b1, 16'h0002, 1'b0, 1'b0);
        rd_reg(8'h20, 16'd1, "R9 X after row wrap");
        rd_reg(8'h21, 16'd3, "R9 Y after row wrap");
        wr_reg(8'h20, 16'd14);
        wr_reg(8'h21, 16'd2);
        rd_reg(8'h22, 16'hFFFF, "R8 pixel 14,2");
        expect_rd(16'hFFFF, "R8 read does not advance");
        wr_reg(8'h20, 16'd15);
        rd_reg(8'h22, 16'h0001, "R8 pixel 15,2");
        wr_reg(8'h20, 16'd0);
        wr_reg(8'h21, 16'd3);
        rd_reg(8'h22, 16'h0002, "R8 pixel 0,3");
        // R9 end of memory wrap
        wr_reg(8'h20, 16'd15);
        wr_reg(8'h21, 16'd7);
        wr_reg(8'h22, 16'hAAAA);
        rd_reg(8'h20, 16'd0, "R9 X end wrap");
        rd_reg(8'h21, 16'd0, "R9 Y end wrap");
        wr_reg(8'h20, 16'd15);
        wr_reg(8'h21, 16'd7);
        rd_reg(8'h22, 16'hAAAA, "R8 last pixel");
        // R10 truncation
        wr_reg(8'h20, 16'h0013);
        rd_reg(8'h20, 16'h0003, "R10 X low bits");
        wr_reg(8'h21, 16'h000D);
        rd_reg(8'h21, 16'h0005, "R10 Y low bits");
        // R1 reset mid run
        @(posedge clk); #2;
        bus_rst_n = 1'b0;
        repeat (2) @(posedge clk); #2;
        bus_rst_n = 1'b1;
        expect_rd(16'h5A17, "R1 index after reset");
        rd_reg(8'h03, 16'h0000, "R1 mode after reset");
        rd_reg(8'h07, 16'h0000, "R1 disp after reset");
        rd_reg(8'h20, 16'h0000, "R1 X after reset");
        rd_reg(8'h21, 16'h0000, "R1 Y after reset");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule